// File: doc/BRIEF.md
# Deblocking edge sample filter

This block smooths one line of eight samples that crosses a block boundary in a reconstructed picture. Four samples lie on the near side of the edge (p0 closest, out to p3) and four on the far side (q0 closest, out to q3). Along with the line it receives an edge strength code, a luma/chroma select and three thresholds that an upstream table stage has already looked up: alpha, beta and tc0. It then returns the line with the smoothed samples in place.

Inside, one datapath covers the whole line. It runs the gating tests, the strong smoothing used at strength 4 and the clipped correction used at strengths 1 to 3, and a mode selector picks one result for each side of the edge. So each sample takes no branch of its own. The result is registered and marked with a valid strobe one clock after the input, and a new line may enter on every clock.

Top module: `dbk_line_filter`

## Requirements
- R1: While rst_n is low, out_valid is 0 and p_out and q_out are all zero.
- R2: out_valid equals in_valid of the previous clock, and the outputs carry the line accepted on that clock, so a new line may enter on every clock.
- R3: The line leaves unchanged unless all of these hold: bs is non-zero, |p0-q0| < alpha, |p1-p0| < beta and |q1-q0| < beta.
- R4: For luma, with bs of 4 or more and the gate of R3 open, a side whose |x2-x0| < beta, where |p0-q0| < (alpha>>2)+2, takes three new values: x0 = (x2+2x1+2x0+2y0+y1+4)>>3, x1 = (x2+x1+x0+y0+2)>>2, x2 = (2x3+3x2+x1+x0+y0+4)>>3. Here x is that side and y is the opposite side.
- R5: For luma in the strong mode, a side that fails either condition of R4 changes only x0, to (2x1+x0+y1+2)>>2.
- R6: For chroma in the strong mode, p0 becomes (2p1+p0+q1+2)>>2 and q0 becomes (2q1+q0+p1+2)>>2.
- R7: For bs 1 to 3, the step d = (4(q0-p0)+(p1-q1)+4)>>3 is taken with a floor shift and clipped to [-tc, tc]. Then p0 becomes p0+d and q0 becomes q0-d, each saturated to 0..255.
- R8: tc is tc0+1 for chroma. For luma it is tc0 plus one for each side whose |x2-x0| < beta.
- R9: For luma with bs 1 to 3, a side whose |x2-x0| < beta adds to x1 the clip to [-tc0, tc0] of (x2+((p0+q0+1)>>1)-2x1)>>1. The other side keeps x1.
- R10: p3 and q3 never change. For chroma, p1, p2, q1 and q2 never change.
- R11: bs values 5 to 7 give the same result as bs 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A line is presented this clock |
| bs | input | 3 | Edge strength code, 0 to 7 |
| is_luma | input | 1 | 1 for luma, 0 for chroma |
| alpha | input | 8 | Edge step threshold |
| beta | input | 8 | Side activity threshold |
| tc0 | input | 5 | Base clip limit |
| p_in | input | 4x8 | Near-side samples, element k is pk |
| q_in | input | 4x8 | Far-side samples, element k is qk |
| out_valid | output | 1 | Registered line is valid |
| p_out | output | 4x8 | Filtered near-side samples |
| q_out | output | 4x8 | Filtered far-side samples |

## Verification
The only state is the output register. If the line is captured wrongly, or the mode is chosen wrongly, the fault shows on p_out or q_out at the first sample after the clock that took that line in. A wrong gate shows up as a smoothed line that should have passed through, or the reverse, and a wrong sign or shift shows up as values that differ from the arithmetic by one or more codes. The sweeps hold the samples of each side close to a shared level and vary the thresholds, so every mode, every side-acceptance combination and both saturation limits are reached over many lines.

// File: rtl/dbk_pkg.sv
// Shared definitions for the edge line filter.
// Assumes samples are unsigned and that the thresholds come already looked up.
package dbk_pkg;
    typedef enum logic [1:0] {
        FM_PASS   = 2'd0,
        FM_NORMAL = 2'd1,
        FM_STRONG = 2'd2
    } fmode_e;

    localparam int unsigned DBK_SAMPLE_W  = 8;
    localparam int unsigned DBK_TC_W      = 5;
    localparam int unsigned DBK_BS_W      = 3;
    localparam int unsigned DBK_BS_STRONG = 4;
endpackage

// File: rtl/dbk_gate.sv
// Gating tests for one line: decides the filter mode and the per-side flags.
// Assumes p and q hold the three samples nearest the edge, index 0 nearest.
module dbk_gate #(
    parameter int unsigned SW        = dbk_pkg::DBK_SAMPLE_W,
    parameter int unsigned BSW       = dbk_pkg::DBK_BS_W,
    parameter int unsigned BS_STRONG = dbk_pkg::DBK_BS_STRONG
) (
    input  logic [2:0][SW-1:0] p,
    input  logic [2:0][SW-1:0] q,
    input  logic [BSW-1:0]     bs,
    input  logic [SW-1:0]      alpha,
    input  logic [SW-1:0]      beta,
    output dbk_pkg::fmode_e    mode,
    output logic               ap_ok,
    output logic               aq_ok,
    output logic               near_ok
);
    localparam logic [SW:0] STRONG_ADD = (SW+1)'(2);

    // Absolute difference of two unsigned samples.
    function automatic logic [SW-1:0] absdiff(input logic [SW-1:0] a, input logic [SW-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [SW-1:0] d_edge;
    logic [SW-1:0] d_p10;
    logic [SW-1:0] d_q10;
    logic [SW:0]   strong_lim;
    logic          open;

    assign d_edge     = absdiff(p[0], q[0]);
    assign d_p10      = absdiff(p[1], p[0]);
    assign d_q10      = absdiff(q[1], q[0]);
    assign strong_lim = ({1'b0, alpha} >> 2) + STRONG_ADD;

    assign open    = (bs != '0) && (d_edge < alpha) && (d_p10 < beta) && (d_q10 < beta);
    assign ap_ok   = absdiff(p[2], p[0]) < beta;
    assign aq_ok   = absdiff(q[2], q[0]) < beta;
    assign near_ok = {1'b0, d_edge} < strong_lim;

    // Pick one mode for the line from the gate and the strength code.
    always_comb begin
        if (!open) begin
            mode = dbk_pkg::FM_PASS;
        end else if (bs >= BSW'(BS_STRONG)) begin
            mode = dbk_pkg::FM_STRONG;
        end else begin
            mode = dbk_pkg::FM_NORMAL;
        end
    end
endmodule

// File: rtl/dbk_strong_side.sv
// Strong-mode result for one side of the edge.
// own is that side (index 0 nearest the edge), opp0/opp1 the opposite side.
// full selects the three-sample smoothing; otherwise only sample 0 changes.
module dbk_strong_side #(
    parameter int unsigned SW = dbk_pkg::DBK_SAMPLE_W
) (
    input  logic [3:0][SW-1:0] own,
    input  logic [SW-1:0]      opp0,
    input  logic [SW-1:0]      opp1,
    input  logic               full,
    output logic [2:0][SW-1:0] res
);
    localparam int unsigned AW = SW + 4;
    localparam logic [AW-1:0] K1 = AW'(1);
    localparam logic [AW-1:0] K2 = AW'(2);
    localparam logic [AW-1:0] K3 = AW'(3);
    localparam logic [AW-1:0] K4 = AW'(4);

    logic [AW-1:0] x0, x1, x2, x3, y0, y1;
    logic [AW-1:0] sum0, sum1, sum2, alt0;

    assign x0 = AW'(own[0]);
    assign x1 = AW'(own[1]);
    assign x2 = AW'(own[2]);
    assign x3 = AW'(own[3]);
    assign y0 = AW'(opp0);
    assign y1 = AW'(opp1);

    assign sum0 = x2 + K2*x1 + K2*x0 + K2*y0 + K1*y1 + K4;
    assign sum1 = x2 + x1 + x0 + y0 + K2;
    assign sum2 = K2*x3 + K3*x2 + x1 + x0 + y0 + K4;
    assign alt0 = K2*x1 + x0 + y1 + K2;

    // Select the full three-tap update or the single-sample fallback.
    always_comb begin
        res[0] = full ? sum0[SW+2:3] : alt0[SW+1:2];
        res[1] = full ? sum1[SW+1:2] : own[1];
        res[2] = full ? sum2[SW+2:3] : own[2];
    end
endmodule

// File: rtl/dbk_normal.sv
// Clipped-correction result (strength 1..3) for both sides of the edge.
// res[0] is the near side, res[1] the far side; index 0 is the sample at the edge.
module dbk_normal #(
    parameter int unsigned SW  = dbk_pkg::DBK_SAMPLE_W,
    parameter int unsigned TCW = dbk_pkg::DBK_TC_W
) (
    input  logic [2:0][SW-1:0]      p,
    input  logic [2:0][SW-1:0]      q,
    input  logic                    is_luma,
    input  logic [TCW-1:0]          tc0,
    input  logic                    ap_ok,
    input  logic                    aq_ok,
    output logic [1:0][1:0][SW-1:0] res
);
    localparam int unsigned AW = ((SW > TCW) ? SW : TCW) + 4;
    typedef logic signed [AW-1:0] sv_t;
    localparam sv_t SAMPLE_MAX = sv_t'((1 << SW) - 1);

    // Zero-extend a sample into the signed working width.
    function automatic sv_t s_ext(input logic [SW-1:0] x);
        return sv_t'({{(AW-SW){1'b0}}, x});
    endfunction

    // Zero-extend a clip limit into the signed working width.
    function automatic sv_t t_ext(input logic [TCW-1:0] x);
        return sv_t'({{(AW-TCW){1'b0}}, x});
    endfunction

    // Limit v to the symmetric range [-lim, lim].
    function automatic sv_t clip_sym(input sv_t v, input sv_t lim);
        if (v > lim) return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    // Saturate a signed value to the sample range.
    function automatic logic [SW-1:0] sat(input sv_t v);
        if (v < sv_t'(0)) return '0;
        if (v > SAMPLE_MAX) return '1;
        return v[SW-1:0];
    endfunction

    logic [1:0][2:0][SW-1:0] side_s;
    logic [1:0]              side_ok;
    sv_t                     step_raw, step_c, tc_lim, avg;

    assign side_s[0] = p;
    assign side_s[1] = q;
    assign side_ok   = {aq_ok, ap_ok};

    assign step_raw = (((s_ext(q[0]) - s_ext(p[0])) <<< 2) + (s_ext(p[1]) - s_ext(q[1])) + sv_t'(4)) >>> 3;
    assign tc_lim   = is_luma ? (t_ext(tc0) + sv_t'(ap_ok) + sv_t'(aq_ok)) : (t_ext(tc0) + sv_t'(1));
    assign step_c   = clip_sym(step_raw, tc_lim);
    assign avg      = (s_ext(p[0]) + s_ext(q[0]) + sv_t'(1)) >>> 1;

    assign res[0][0] = sat(s_ext(p[0]) + step_c);
    assign res[1][0] = sat(s_ext(q[0]) - step_c);

    for (genvar g = 0; g < 2; g++) begin : g_side
        sv_t tap, tap_c;
        assign tap   = (s_ext(side_s[g][2]) + avg - (s_ext(side_s[g][1]) <<< 1)) >>> 1;
        assign tap_c = clip_sym(tap, t_ext(tc0));
        assign res[g][1] = (is_luma && side_ok[g]) ? sat(s_ext(side_s[g][1]) + tap_c) : side_s[g][1];
    end
endmodule

// File: rtl/dbk_line_filter.sv
// Edge line filter top: gate, strong and normal datapaths, mode mux, output register.
// Assumes one line per clock when in_valid is high; thresholds are valid with the line.
module dbk_line_filter #(
    parameter int unsigned SW        = dbk_pkg::DBK_SAMPLE_W,
    parameter int unsigned TCW       = dbk_pkg::DBK_TC_W,
    parameter int unsigned BSW       = dbk_pkg::DBK_BS_W,
    parameter int unsigned BS_STRONG = dbk_pkg::DBK_BS_STRONG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [BSW-1:0]      bs,
    input  logic                is_luma,
    input  logic [SW-1:0]       alpha,
    input  logic [SW-1:0]       beta,
    input  logic [TCW-1:0]      tc0,
    input  logic [3:0][SW-1:0]  p_in,
    input  logic [3:0][SW-1:0]  q_in,
    output logic                out_valid,
    output logic [3:0][SW-1:0]  p_out,
    output logic [3:0][SW-1:0]  q_out
);
    localparam int unsigned SIDES = 2;

    dbk_pkg::fmode_e               mode;
    logic                          ap_ok, aq_ok, near_ok;
    logic [SIDES-1:0][3:0][SW-1:0] own_s;
    logic [SIDES-1:0]              full_ok;
    logic [SIDES-1:0][2:0][SW-1:0] strong_res;
    logic [SIDES-1:0][1:0][SW-1:0] normal_res;
    logic [SIDES-1:0][3:0][SW-1:0] next_s;

    assign own_s[0] = p_in;
    assign own_s[1] = q_in;
    assign full_ok  = {is_luma && aq_ok && near_ok, is_luma && ap_ok && near_ok};

    dbk_gate #(.SW(SW), .BSW(BSW), .BS_STRONG(BS_STRONG)) u_gate (
        .p       (p_in[2:0]),
        .q       (q_in[2:0]),
        .bs      (bs),
        .alpha   (alpha),
        .beta    (beta),
        .mode    (mode),
        .ap_ok   (ap_ok),
        .aq_ok   (aq_ok),
        .near_ok (near_ok)
    );

    dbk_normal #(.SW(SW), .TCW(TCW)) u_normal (
        .p       (p_in[2:0]),
        .q       (q_in[2:0]),
        .is_luma (is_luma),
        .tc0     (tc0),
        .ap_ok   (ap_ok),
        .aq_ok   (aq_ok),
        .res     (normal_res)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dbk_strong_side #(.SW(SW)) u_strong (
            .own  (own_s[g]),
            .opp0 (own_s[SIDES-1-g][0]),
            .opp1 (own_s[SIDES-1-g][1]),
            .full (full_ok[g]),
            .res  (strong_res[g])
        );

        // Choose this side's next samples from the selected mode.
        always_comb begin
            next_s[g] = own_s[g];
            case (mode)
                dbk_pkg::FM_STRONG: next_s[g][2:0] = strong_res[g];
                dbk_pkg::FM_NORMAL: next_s[g][1:0] = normal_res[g];
                default:            next_s[g] = own_s[g];
            endcase
        end
    end

    // Register the filtered line and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            p_out     <= '0;
            q_out     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                p_out <= next_s[0];
                q_out <= next_s[1];
            end
        end
    end
endmodule

// File: rtl/dbk_line_filter_chk.sv
// Property checker for the edge line filter, attached by bind.
// Keeps a copy of the previous clock's inputs to relate outputs to them.
module dbk_line_filter_chk #(
    parameter int unsigned SW  = dbk_pkg::DBK_SAMPLE_W,
    parameter int unsigned TCW = dbk_pkg::DBK_TC_W,
    parameter int unsigned BSW = dbk_pkg::DBK_BS_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [BSW-1:0]     bs,
    input logic               is_luma,
    input logic [TCW-1:0]     tc0,
    input logic [3:0][SW-1:0] p_in,
    input logic [3:0][SW-1:0] q_in,
    input logic               out_valid,
    input logic [3:0][SW-1:0] p_out,
    input logic [3:0][SW-1:0] q_out
);
    logic [BSW-1:0]     prev_bs;
    logic               prev_luma;
    logic [TCW-1:0]     prev_tc0;
    logic [3:0][SW-1:0] prev_p, prev_q;
    logic [SW-1:0]      p0_step;
    logic [SW:0]        chroma_lim;

    // Hold the inputs of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_bs   <= '0;
            prev_luma <= 1'b0;
            prev_tc0  <= '0;
            prev_p    <= '0;
            prev_q    <= '0;
        end else begin
            prev_bs   <= bs;
            prev_luma <= is_luma;
            prev_tc0  <= tc0;
            prev_p    <= p_in;
            prev_q    <= q_in;
        end
    end

    assign p0_step    = (p_out[0] > prev_p[0]) ? (p_out[0] - prev_p[0]) : (prev_p[0] - p_out[0]);
    assign chroma_lim = (SW+1)'(prev_tc0) + (SW+1)'(1);

    // R1
    r1_reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R2
    r2_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    r2_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    r3_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && prev_bs == '0) |-> (p_out == prev_p && q_out == prev_q));

    // R10
    r10_outer_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (p_out[3] == prev_p[3] && q_out[3] == prev_q[3]));

    // R10
    r10_chroma_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !prev_luma) |-> (p_out[2:1] == prev_p[2:1] && q_out[2:1] == prev_q[2:1]));

    // R7
    r7_chroma_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !prev_luma && prev_bs != '0 && prev_bs < BSW'(4)) |-> ({1'b0, p0_step} <= chroma_lim));
endmodule

bind dbk_line_filter dbk_line_filter_chk #(.SW(SW), .TCW(TCW), .BSW(BSW)) u_dbk_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .bs        (bs),
    .is_luma   (is_luma),
    .tc0       (tc0),
    .p_in      (p_in),
    .q_in      (q_in),
    .out_valid (out_valid),
    .p_out     (p_out),
    .q_out     (q_out)
);

// File: tb/test_dbk_line_filter.sv
`timescale 1ns/1ps
// Bench for the edge line filter: directed corners plus swept clustered lines.
module test_dbk_line_filter;
    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [2:0]      bs;
    logic            is_luma;
    logic [7:0]      alpha, beta;
    logic [4:0]      tc0;
    logic [3:0][7:0] p_in, q_in;
    logic            out_valid;
    logic [3:0][7:0] p_out, q_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dbk_line_filter i_dbk_line_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bs(bs), .is_luma(is_luma),
        .alpha(alpha), .beta(beta), .tc0(tc0), .p_in(p_in), .q_in(q_in),
        .out_valid(out_valid), .p_out(p_out), .q_out(q_out)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int clipi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // Expected line from the requirements, with the tag of the mode it exercises.
    function automatic void model(input logic [3:0][7:0] p, input logic [3:0][7:0] q,
                                  input int b, input int lu, input int al, input int be, input int t0,
                                  output logic [3:0][7:0] ep, output logic [3:0][7:0] eq,
                                  output string tag);
        int pv[4];
        int qv[4];
        int ap, aq, tc, d, avg;
        bit en, fp, fq;
        for (int k = 0; k < 4; k++) begin
            pv[k] = int'(p[k]);
            qv[k] = int'(q[k]);
        end
        ep = p;
        eq = q;
        en = (b != 0) && (iabs(pv[0]-qv[0]) < al) && (iabs(pv[1]-pv[0]) < be) && (iabs(qv[1]-qv[0]) < be);
        ap = iabs(pv[2]-pv[0]);
        aq = iabs(qv[2]-qv[0]);
        tag = "R3";
        if (en && b >= 4) begin
            if (lu != 0) begin
                fp = (ap < be) && (iabs(pv[0]-qv[0]) < ((al >> 2) + 2));
                fq = (aq < be) && (iabs(pv[0]-qv[0]) < ((al >> 2) + 2));
                tag = (fp || fq) ? "R4" : "R5";
                if (fp) begin
                    ep[0] = 8'((pv[2] + 2*pv[1] + 2*pv[0] + 2*qv[0] + qv[1] + 4) >> 3);
                    ep[1] = 8'((pv[2] + pv[1] + pv[0] + qv[0] + 2) >> 2);
                    ep[2] = 8'((2*pv[3] + 3*pv[2] + pv[1] + pv[0] + qv[0] + 4) >> 3);
                end else begin
                    ep[0] = 8'((2*pv[1] + pv[0] + qv[1] + 2) >> 2);
                end
                if (fq) begin
                    eq[0] = 8'((qv[2] + 2*qv[1] + 2*qv[0] + 2*pv[0] + pv[1] + 4) >> 3);
                    eq[1] = 8'((qv[2] + qv[1] + qv[0] + pv[0] + 2) >> 2);
                    eq[2] = 8'((2*qv[3] + 3*qv[2] + qv[1] + qv[0] + pv[0] + 4) >> 3);
                end else begin
                    eq[0] = 8'((2*qv[1] + qv[0] + pv[1] + 2) >> 2);
                end
            end else begin
                tag = "R6";
                ep[0] = 8'((2*pv[1] + pv[0] + qv[1] + 2) >> 2);
                eq[0] = 8'((2*qv[1] + qv[0] + pv[1] + 2) >> 2);
            end
            if (b > 4) tag = "R11";
        end else if (en) begin
            tc = (lu != 0) ? (t0 + ((ap < be) ? 1 : 0) + ((aq < be) ? 1 : 0)) : (t0 + 1);
            d = (4*(qv[0]-pv[0]) + (pv[1]-qv[1]) + 4) >>> 3;
            d = clipi(d, -tc, tc);
            ep[0] = 8'(clipi(pv[0] + d, 0, 255));
            eq[0] = 8'(clipi(qv[0] - d, 0, 255));
            tag = "R7";
            if (lu != 0) begin
                tag = "R9";
                avg = (pv[0] + qv[0] + 1) >> 1;
                if (ap < be) ep[1] = 8'(clipi(pv[1] + clipi((pv[2] + avg - 2*pv[1]) >>> 1, -t0, t0), 0, 255));
                if (aq < be) eq[1] = 8'(clipi(qv[1] + clipi((qv[2] + avg - 2*qv[1]) >>> 1, -t0, t0), 0, 255));
            end
        end
    endfunction

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Present one line at a falling edge and check it one clock later.
    task automatic apply(input string tag_in, input logic [3:0][7:0] p, input logic [3:0][7:0] q,
                         input int b, input int lu, input int al, input int be, input int t0);
        logic [3:0][7:0] ep, eq;
        string tag;
        model(p, q, b, lu, al, be, t0, ep, eq, tag);
        if (tag_in != "") tag = tag_in;
        in_valid = 1'b1;
        p_in = p; q_in = q;
        bs = 3'(b); is_luma = lu[0];
        alpha = 8'(al); beta = 8'(be); tc0 = 5'(t0);
        @(negedge clk);
        check(tag, {out_valid, p_out, q_out}, {1'b1, ep, eq});
    endtask

    // Fixed-value check: the expected line is written out by hand.
    task automatic apply_fixed(input string tag, input logic [3:0][7:0] p, input logic [3:0][7:0] q,
                               input int b, input int lu, input int al, input int be, input int t0,
                               input logic [3:0][7:0] ep, input logic [3:0][7:0] eq);
        in_valid = 1'b1;
        p_in = p; q_in = q;
        bs = 3'(b); is_luma = lu[0];
        alpha = 8'(al); beta = 8'(be); tc0 = 5'(t0);
        @(negedge clk);
        check(tag, {out_valid, p_out, q_out}, {1'b1, ep, eq});
    endtask

    function automatic logic [7:0] near_val(input int base, input int spread);
        return 8'(clipi(base + int'($urandom_range(2*spread, 0)) - spread, 0, 255));
    endfunction

    initial begin
        logic [3:0][7:0] p, q;
        int bp, bq, sp;
        rst_n = 1'b0; in_valid = 1'b0; bs = '0; is_luma = 1'b0;
        alpha = '0; beta = '0; tc0 = '0; p_in = '0; q_in = '0;
        repeat (3) @(negedge clk);
        check("R1", {out_valid, p_out, q_out}, 65'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", {64'd0, out_valid}, 65'd0);

        // R8: luma, both sides accepted, tc = tc0 + 2 limits the step to 2
        apply_fixed("R8", {8'd100, 8'd100, 8'd100, 8'd100}, {8'd110, 8'd110, 8'd110, 8'd110},
                    2, 1, 20, 5, 0,
                    {8'd100, 8'd100, 8'd100, 8'd102}, {8'd110, 8'd110, 8'd110, 8'd108});
        // R8: chroma, tc = tc0 + 1
        apply_fixed("R8", {8'd100, 8'd100, 8'd100, 8'd100}, {8'd110, 8'd110, 8'd110, 8'd110},
                    2, 0, 20, 5, 0,
                    {8'd100, 8'd100, 8'd100, 8'd101}, {8'd110, 8'd110, 8'd110, 8'd109});
        // R8: luma, near side rejected (|p2-p0| = 10), tc = tc0 + 1, p1 kept (R9)
        apply_fixed("R8", {8'd100, 8'd110, 8'd100, 8'd100}, {8'd110, 8'd110, 8'd110, 8'd110},
                    2, 1, 20, 5, 0,
                    {8'd100, 8'd110, 8'd100, 8'd101}, {8'd110, 8'd110, 8'd110, 8'd109});
        // R7: saturation of p0 at zero, chroma, step clipped to 26
        apply_fixed("R7", {8'd0, 8'd0, 8'd0, 8'd5}, {8'd200, 8'd200, 8'd200, 8'd0},
                    1, 0, 50, 255, 25,
                    {8'd0, 8'd0, 8'd0, 8'd0}, {8'd200, 8'd200, 8'd200, 8'd26});
        // R10: chroma strong changes only p0 and q0
        apply_fixed("R10", {8'd40, 8'd50, 8'd62, 8'd60}, {8'd99, 8'd90, 8'd64, 8'd66},
                    4, 0, 20, 10, 3,
                    {8'd40, 8'd50, 8'd62, 8'd62}, {8'd99, 8'd90, 8'd64, 8'd64});
        // R3: zero strength leaves an otherwise filterable line unchanged
        apply_fixed("R3", {8'd100, 8'd100, 8'd100, 8'd100}, {8'd110, 8'd110, 8'd110, 8'd110},
                    0, 1, 20, 5, 4,
                    {8'd100, 8'd100, 8'd100, 8'd100}, {8'd110, 8'd110, 8'd110, 8'd110});
        // R11: strength 7 on a luma line equals strength 4
        apply("R11", {8'd70, 8'd72, 8'd74, 8'd75}, {8'd79, 8'd80, 8'd82, 8'd78}, 7, 1, 30, 8, 2);
        apply("R4",  {8'd70, 8'd72, 8'd74, 8'd75}, {8'd79, 8'd80, 8'd82, 8'd78}, 4, 1, 30, 8, 2);

        // Swept lines: clustered sample levels, all strengths, both planes
        for (int lu = 0; lu < 2; lu++) begin
            for (int b = 0; b < 8; b++) begin
                for (int k = 0; k < 600; k++) begin
                    bp = (k % 16 == 0) ? 3 : ((k % 16 == 1) ? 252 : int'($urandom_range(255, 0)));
                    bq = clipi(bp + int'($urandom_range(60, 0)) - 30, 0, 255);
                    sp = (k % 4 == 0) ? 30 : ((k % 4 == 1) ? 10 : ((k % 4 == 2) ? 4 : 1));
                    for (int j = 0; j < 4; j++) begin
                        p[j] = near_val(bp, sp);
                        q[j] = near_val(bq, sp);
                    end
                    apply("", p, q, b, lu, int'($urandom_range(90, 0)),
                          int'($urandom_range(24, 0)), int'($urandom_range(25, 0)));
                end
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        check("R2", {64'd0, out_valid}, 65'd0);
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            report();
            $finish;
        end
    end
endmodule